// File: doc/BRIEF.md
# Mixed-Depth Pixel Source Selector

This stage produces one 32-bit display pixel per clock from three planes presented side by side: an 8-bit colour index, a 32-bit direct-colour word and a 32-bit control word. The top byte of the control word picks the source for that pixel alone. A tag of 0x03 takes the colour straight from the direct-colour word. Any other tag sends the index to an external 256-entry palette and uses the colour that comes back. A screen line may therefore mix true-colour and indexed pixels freely. No global mode bit is involved.

The palette sits outside the block. The stage issues a read strobe and an address in the cycle a pixel is accepted. It expects the palette colour exactly `LOOKUP_LAT` cycles later. Direct pixels travel through a matching delay line, so every pixel leaves in the order it arrived. A per-pixel order input chooses RGB or BGR packing of the result.

Top module: `pixsel_top`

## Requirements
- R1: A pixel takes the direct path only when bits 31:24 of its control word equal 0x03; bits 23:0 of the control word never affect the result. Tags such as 0x00, 0x02, 0x04 and 0xFF select the palette path.
- R2: For an accepted palette-path pixel, `palRdEn` is high and `palAddr` equals `indexByte` in the same cycle. For a direct-path pixel, or when `inValid` is low, `palRdEn` is low. The colour on `palData` exactly `LOOKUP_LAT` cycles later is the one used.
- R3: On the direct path, bits 31:24 of `directWord` are ignored. Bits 23:16 are blue, bits 15:8 are green and bits 7:0 are red.
- R4: Palette colours are read as red in `palData[23:16]`, green in `[15:8]` and blue in `[7:0]`, with `[31:24]` ignored. With `useBgr`=0 the output is 0x00RRGGBB. With `useBgr`=1 it is 0x00BBGGRR. `useBgr` is taken per pixel, in the same cycle as the pixel.
- R5: A pixel accepted in cycle c appears with `outValid` high in cycle c+`LOOKUP_LAT`+1. One pixel is accepted per clock, with no stall. Outputs keep input order.
- R6: In a cycle with `outValid` low, `pixOut` keeps the last pixel delivered.
- R7: While `rst` is high and after it falls, `outValid` and `pixOut` are zero until the first pixel arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Pixel present on the input planes this cycle |
| indexByte | input | 8 | Indexed-plane byte (palette index) |
| directWord | input | 32 | Direct-colour plane word |
| ctrlWord | input | 32 | Control plane word; top byte is the source tag |
| useBgr | input | 1 | Output order for this pixel: 0 RGB, 1 BGR |
| palRdEn | output | 1 | Palette read strobe |
| palAddr | output | 8 | Palette read address |
| palData | input | 32 | Palette colour, `LOOKUP_LAT` cycles after the strobe |
| outValid | output | 1 | Output pixel valid |
| pixOut | output | 32 | Packed output pixel |

## Verification
The palette strobe and address are combinational, so the bench checks them one time step after it drives a pixel, inside the same cycle. Every output pixel is due in cycle c+`LOOKUP_LAT`+1. The driver stamps each expected pixel with that due cycle before pushing it into the scoreboard queue. The monitor samples on the falling edge and fails any pixel that arrives early, late or out of order. In every idle output cycle the monitor also checks that the held value has not moved. The bench's palette model returns a poison word for any cycle without a strobe, so a wrong address or a missing strobe shows up in the data.

// File: rtl/pixsel_pkg.sv
package pixsel_pkg;

  localparam logic [7:0] DIRECT_TAG = 8'h03;

  // strobes handed from control to datapath at the output stage
  typedef struct packed {
    logic loadOut;    // a pixel reaches the output register this cycle
    logic useDirect;  // take the delayed direct colour, not the palette
    logic useBgr;     // component order for this pixel
  } pixStrobe_t;

  function automatic logic [31:0] packColor(input logic [7:0] red,
                                            input logic [7:0] green,
                                            input logic [7:0] blue,
                                            input logic       bgrOrder);
    if (bgrOrder) packColor = {8'h00, blue, green, red};
    else          packColor = {8'h00, red, green, blue};
  endfunction

endpackage

// File: rtl/pixsel_ctrl.sv
module pixsel_ctrl
  import pixsel_pkg::*;
#(
  parameter int LOOKUP_LAT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [7:0] ctrlTag,
  input  logic       useBgr,
  output logic       palRdEn,
  output pixStrobe_t stb,
  output logic       outValid
);

  localparam int CW = $clog2(LOOKUP_LAT + 3);

  logic isDirect;
  logic [LOOKUP_LAT-1:0] vPipe, dPipe, bPipe;

  assign isDirect = (ctrlTag == DIRECT_TAG);
  assign palRdEn  = inValid && !isDirect && !rst;

  // stage 0 captures the input, later stages shift
  always_ff @(posedge clk) begin
    if (rst) begin
      vPipe[0] <= 1'b0;
      dPipe[0] <= 1'b0;
      bPipe[0] <= 1'b0;
    end else begin
      vPipe[0] <= inValid;
      dPipe[0] <= isDirect;
      bPipe[0] <= useBgr;
    end
  end

  for (genvar s = 1; s < LOOKUP_LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        vPipe[s] <= 1'b0;
        dPipe[s] <= 1'b0;
        bPipe[s] <= 1'b0;
      end else begin
        vPipe[s] <= vPipe[s-1];
        dPipe[s] <= dPipe[s-1];
        bPipe[s] <= bPipe[s-1];
      end
    end
  end

  assign stb.loadOut   = vPipe[LOOKUP_LAT-1];
  assign stb.useDirect = dPipe[LOOKUP_LAT-1];
  assign stb.useBgr    = bPipe[LOOKUP_LAT-1];

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= stb.loadOut;
  end

  // occupancy counters guarding R2 and R5
  logic [CW-1:0] inFlight, palPending;
  always_ff @(posedge clk) begin
    if (rst) begin
      inFlight   <= '0;
      palPending <= '0;
    end else begin
      inFlight   <= inFlight + CW'(inValid) - CW'(outValid);
      palPending <= palPending + CW'(palRdEn) - CW'(stb.loadOut && !stb.useDirect);
    end
  end

  a_r5_in_flight_bound: assert property (@(posedge clk) disable iff (rst)
    inFlight <= CW'(LOOKUP_LAT + 1));

  a_r2_palette_pending_bound: assert property (@(posedge clk) disable iff (rst)
    palPending <= CW'(LOOKUP_LAT));

  a_r2_no_strobe_idle: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> !palRdEn);

endmodule

// File: rtl/pixsel_dpath.sv
module pixsel_dpath
  import pixsel_pkg::*;
#(
  parameter int LOOKUP_LAT = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [23:0] directBgr,
  input  logic        useBgr,
  input  logic [23:0] palRgb,
  input  pixStrobe_t  stb,
  output logic [31:0] pixOut
);

  logic [31:0] directPacked;
  logic [31:0] palPacked;
  logic [23:0] dlyLine [LOOKUP_LAT];

  // direct word bytes: blue 23:16, green 15:8, red 7:0
  assign directPacked = packColor(directBgr[7:0], directBgr[15:8],
                                  directBgr[23:16], useBgr);

  always_ff @(posedge clk) begin
    if (rst) dlyLine[0] <= '0;
    else     dlyLine[0] <= directPacked[23:0];
  end

  for (genvar s = 1; s < LOOKUP_LAT; s++) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) dlyLine[s] <= '0;
      else     dlyLine[s] <= dlyLine[s-1];
    end
  end

  assign palPacked = packColor(palRgb[23:16], palRgb[15:8], palRgb[7:0],
                               stb.useBgr);

  always_ff @(posedge clk) begin
    if (rst) begin
      pixOut <= '0;
    end else if (stb.loadOut) begin
      pixOut <= stb.useDirect ? {8'h00, dlyLine[LOOKUP_LAT-1]} : palPacked;
    end
  end

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !stb.loadOut |=> $stable(pixOut));

  a_r4_top_byte_clear: assert property (@(posedge clk) disable iff (rst)
    stb.loadOut |=> pixOut[31:24] == 8'h00);

endmodule

// File: rtl/pixsel_top.sv
module pixsel_top
  import pixsel_pkg::*;
#(
  parameter int LOOKUP_LAT = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [7:0]  indexByte,
  input  logic [31:0] directWord,
  input  logic [31:0] ctrlWord,
  input  logic        useBgr,
  output logic        palRdEn,
  output logic [7:0]  palAddr,
  input  logic [31:0] palData,
  output logic        outValid,
  output logic [31:0] pixOut
);

  pixStrobe_t stb;

  // bytes that play no part in the result
  logic unusedBits;
  assign unusedBits = ^{ctrlWord[23:0], directWord[31:24], palData[31:24]};

  assign palAddr = indexByte;

  pixsel_ctrl #(.LOOKUP_LAT(LOOKUP_LAT)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctrlTag  (ctrlWord[31:24]),
    .useBgr   (useBgr),
    .palRdEn  (palRdEn),
    .stb      (stb),
    .outValid (outValid)
  );

  pixsel_dpath #(.LOOKUP_LAT(LOOKUP_LAT)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .directBgr (directWord[23:0]),
    .useBgr    (useBgr),
    .palRgb    (palData[23:0]),
    .stb       (stb),
    .pixOut    (pixOut)
  );

  a_r7_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !outValid && pixOut == 32'h0);

endmodule

// File: tb/pixsel_top_bench.sv
module pixsel_top_bench;

  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [7:0]  indexByte = '0;
  logic [31:0] directWord = '0;
  logic [31:0] ctrlWord = '0;
  logic        useBgr = 1'b0;
  logic        palRdEn;
  logic [7:0]  palAddr;
  logic [31:0] palData;
  logic        outValid;
  logic [31:0] pixOut;

  always #2 clk = ~clk;  // 250 MHz

  pixsel_top #(.LOOKUP_LAT(LAT)) u_pixsel_top (
    .clk(clk), .rst(rst), .inValid(inValid), .indexByte(indexByte),
    .directWord(directWord), .ctrlWord(ctrlWord), .useBgr(useBgr),
    .palRdEn(palRdEn), .palAddr(palAddr), .palData(palData),
    .outValid(outValid), .pixOut(pixOut)
  );

  // palette model: colour table computed, poison when not strobed
  function automatic logic [31:0] palColor(input logic [7:0] idx);
    palColor = {idx ^ 8'hA5, idx, ~idx, idx + 8'h3C};
  endfunction

  logic [31:0] palPipe [LAT];
  always_ff @(posedge clk) begin
    palPipe[0] <= palRdEn ? palColor(palAddr) : 32'hFFFF_FFFF;
    for (int s = 1; s < LAT; s++) palPipe[s] <= palPipe[s-1];
  end
  assign palData = palPipe[LAT-1];

  typedef struct {
    logic [31:0] pix;
    int          due;
    string       req;
  } expItem_t;

  expItem_t sb[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  logic [31:0] lastOut = '0;
  bit monOn = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] pk(input logic [7:0] r, input logic [7:0] g,
                                     input logic [7:0] b, input bit bgr);
    pk = bgr ? {8'h00, b, g, r} : {8'h00, r, g, b};
  endfunction

  // drive one pixel at the falling edge, predict and enqueue
  task automatic sendPix(input logic [7:0] tag, input logic [23:0] ctrlLow,
                         input logic [7:0] idx, input logic [31:0] dw,
                         input bit bgr);
    expItem_t it;
    logic [31:0] c;
    bit direct;
    @(negedge clk);
    inValid = 1'b1; indexByte = idx; directWord = dw;
    ctrlWord = {tag, ctrlLow}; useBgr = bgr;
    direct = (tag == 8'h03);
    if (direct) begin
      it.pix = pk(dw[7:0], dw[15:8], dw[23:16], bgr);   // R3, R4
      it.req = bgr ? "R3/R4 direct BGR" : "R3/R4 direct RGB";
    end else begin
      c = palColor(idx);
      it.pix = pk(c[23:16], c[15:8], c[7:0], bgr);      // R2, R4
      it.req = bgr ? "R1/R4 palette BGR" : "R1/R4 palette RGB";
    end
    it.due = cyc + LAT + 1;                              // R5
    sb.push_back(it);
    #1;
    check(palRdEn == !direct, "R1 strobe by tag", {31'd0, palRdEn}, {31'd0, !direct});
    if (!direct) check(palAddr == idx, "R2 palette address", {24'd0, palAddr}, {24'd0, idx});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; ctrlWord = 32'h0300_0000; indexByte = 8'h77;
      #1;
      check(palRdEn == 1'b0, "R2 no strobe when idle", {31'd0, palRdEn}, 32'd0);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (monOn) begin
      if (outValid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R5 unexpected output", pixOut, 32'h0);
        end else begin
          expItem_t it;
          it = sb.pop_front();
          check(pixOut == it.pix, it.req, pixOut, it.pix);
          check(it.due == cyc, "R5 latency", 32'(cyc), 32'(it.due));
          lastOut = it.pix;
        end
      end else begin
        check(pixOut == lastOut, "R6 hold when idle", pixOut, lastOut);
        if (sb.size() != 0 && sb[0].due <= cyc)
          check(1'b0, "R5 missing output", 32'h0, sb[0].pix);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(outValid == 1'b0, "R7 reset valid", {31'd0, outValid}, 32'd0);
    check(pixOut == 32'h0, "R7 reset pixel", pixOut, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0 && pixOut == 32'h0, "R7 after reset", pixOut, 32'h0);
    monOn = 1'b1;

    // mixed line, back to back: tags around 0x03 and odd low bits (R1)
    sendPix(8'h03, 24'h000000, 8'h10, 32'hEE_112233, 1'b0);
    sendPix(8'h02, 24'h000000, 8'h11, 32'h00_445566, 1'b0);
    sendPix(8'h04, 24'h000000, 8'h12, 32'h00_778899, 1'b0);
    sendPix(8'h03, 24'hFFFFFF, 8'h13, 32'h5A_A1B2C3, 1'b1);
    sendPix(8'h00, 24'h000003, 8'h14, 32'h00_D4E5F6, 1'b1);
    sendPix(8'hFF, 24'h030303, 8'hFF, 32'h00_010203, 1'b0);
    sendPix(8'h03, 24'h123456, 8'h00, 32'hFF_0A0B0C, 1'b1);
    sendPix(8'h83, 24'h000000, 8'h80, 32'h00_0D0E0F, 1'b1);
    sendPix(8'h13, 24'h000000, 8'h7F, 32'h00_202122, 1'b0);
    sendPix(8'h03, 24'h000000, 8'h55, 32'h00_FFFFFF, 1'b0);
    idle(3);
    // sparse traffic with gaps, alternating order
    for (int i = 0; i < 12; i++) begin
      sendPix((i % 3 == 0) ? 8'h03 : 8'(i), 24'(i * 37), 8'(i * 19 + 5),
              {8'(i), 8'(i * 7), 8'(i * 11), 8'(i * 13)}, i[0]);
      if (i % 4 == 1) idle(1);
    end
    // long direct-only then palette-only run
    for (int i = 0; i < 6; i++) sendPix(8'h03, 24'h0, 8'h00, 32'h00_102030 + 32'(i), 1'b0);
    for (int i = 0; i < 6; i++) sendPix(8'h01, 24'h0, 8'(200 + i), 32'h0, 1'b1);
    idle(LAT + 4);
    check(sb.size() == 0, "R5 all outputs delivered", 32'(sb.size()), 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule